// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

The block collects eight interrupt request lines into a pending-request register, filters them through a per-line mask, and picks the most urgent one. A pick is made only when that line outranks every line still marked in service. When a request wins, the block raises `int_req` toward the processor. The processor accepts it by pulsing `int_ack`, and one cycle later the block returns an identifying vector. That vector joins a 5-bit programmable base with the 3-bit number of the chosen line.

Each accepted line is recorded in an in-service register. While it is recorded, it holds off itself and every lower-ranked line. Software releases it with an end-of-interrupt command on the `cmd_*` port. Commands can clear a named line, or the most urgent in-service line, and can move the lowest-priority position around the ring. An auto-release mode skips the in-service record altogether. Requests can be captured on rising edges or can follow input levels. A level request that vanishes before acceptance yields the vector of line 7, and no line is marked in service.

`int_req` and `int_ack` form a valid/ready pair. A transfer takes place on a rising clock edge where both are high. `int_ack` has no effect while `int_req` is low. `int_req` falls in the cycle after a transfer and is re-evaluated after that. The vector output has no back-pressure: `vec_out` is valid only in the single cycle where `vec_valid` is high.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `int_req` and `vec_valid` are low, nothing is pending or in service, and line 0 ranks highest and line 7 lowest.
- R2: With `cfg_level`=0, a rising edge on a line records a request. The request persists after the line falls. A line held high after its acceptance makes no new request until it falls and rises again.
- R3: With `cfg_level`=1, the pending bit follows the input. If the input falls before acceptance, the vector is {base, 3'b111} and no in-service bit is set.
- R4: A `cfg_mask` bit of 1 keeps the line from raising `int_req`, and a 0 enables it. A masked or blocked request stays pending and is served once unblocked.
- R5: An accepted transfer makes `vec_valid` high for exactly one cycle, on the next edge, with `vec_out` = {`cfg_base`, line number}.
- R6: Acceptance clears the line's pending bit and sets its in-service bit. Lines ranked at or below any in-service line do not raise `int_req`, and higher-ranked lines still do.
- R7: `cmd_op`=3'b001 (non-specific release) clears the in-service bit of highest current rank.
- R8: `cmd_op`=3'b011 clears the in-service bit named by `cmd_line`. `cmd_op`=3'b010 changes nothing.
- R9: `cmd_op`=3'b101 clears the highest-ranked in-service bit and makes that line lowest. `cmd_op`=3'b111 clears line `cmd_line` and makes it lowest. `cmd_op`=3'b110 makes `cmd_line` lowest.
- R10: With `cfg_auto_eoi`=1, acceptance sets no in-service bit. `cmd_op`=3'b100 enables, and 3'b000 disables, making each accepted line lowest in that mode.
- R11: A request latched at a rising edge raises `int_req` at the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines |
| cfg_base | input | 5 | Upper vector bits |
| cfg_level | input | 1 | 1 = level capture, 0 = edge capture |
| cfg_auto_eoi | input | 1 | 1 = no in-service record on acceptance |
| cfg_mask | input | 8 | Per-line disable, 1 = disabled |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Release/rotation opcode |
| cmd_line | input | 3 | Line operand of the command |
| int_req | output | 1 | Interrupt request to processor (valid) |
| int_ack | input | 1 | Acceptance from processor (ready) |
| vec_valid | output | 1 | One-cycle strobe for `vec_out` |
| vec_out | output | 8 | Vector of accepted line |

## Verification
A pulse on `irq_in` is latched at the first rising edge, and `int_req` follows at the second. The bench therefore checks that `int_req` is still low after one edge and high after two. An accepted `int_ack` produces the vector and strobe at the very next edge, and the strobe is checked to be gone one edge later. A command takes effect at its edge, and `int_req` reflects it one edge after that. Inputs change on falling edges, and every check samples on a falling edge once the counted number of rising edges has passed, so no check races the register it observes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    OP_AROT_OFF = 3'b000,
    OP_REL_TOP  = 3'b001,
    OP_IDLE     = 3'b010,
    OP_REL_LINE = 3'b011,
    OP_AROT_ON  = 3'b100,
    OP_ROT_TOP  = 3'b101,
    OP_SET_LOW  = 3'b110,
    OP_ROT_LINE = 3'b111
  } rel_op_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic         level_mode,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic nxt;
    always_comb begin
      if (level_mode) nxt = lines[g] & ~clr[g];
      else            nxt = (pend[g] & ~clr[g]) | (lines[g] & ~prev[g]);
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
        prev[g] <= 1'b0;
      end else begin
        pend[g] <= nxt;
        prev[g] <= lines[g];
      end
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  input  logic [W-1:0] low,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    logic [W-1:0] cand;
    found = 1'b0;
    idx   = low;
    // walk from lowest rank to highest so the last hit is the most urgent
    for (int k = N - 1; k >= 0; k--) begin
      cand = low + W'(k + 1);
      if (vec[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/irq_svc_state.sv
module irq_svc_state #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  irq_pkg::rel_op_e cmd_op,
  input  logic [W-1:0]     cmd_line,
  input  logic             take,
  input  logic [W-1:0]     take_idx,
  input  logic             auto_rel,
  input  logic             top_found,
  input  logic [W-1:0]     top_idx,
  output logic [N-1:0]     isr,
  output logic [W-1:0]     low_ptr
);
  import irq_pkg::*;

  logic         arot;
  logic         arot_n;
  logic [N-1:0] clr;
  logic [N-1:0] set;
  logic [W-1:0] ptr_n;

  always_comb begin
    clr    = '0;
    set    = '0;
    ptr_n  = low_ptr;
    arot_n = arot;
    if (take && !auto_rel) set[take_idx] = 1'b1;
    if (take && auto_rel && arot) ptr_n = take_idx;
    if (cmd_valid) begin
      case (cmd_op)
        OP_REL_TOP:  if (top_found) clr[top_idx] = 1'b1;
        OP_REL_LINE: clr[cmd_line] = 1'b1;
        OP_ROT_TOP:  if (top_found) begin
                       clr[top_idx] = 1'b1;
                       ptr_n        = top_idx;
                     end
        OP_ROT_LINE: begin
                       clr[cmd_line] = 1'b1;
                       ptr_n         = cmd_line;
                     end
        OP_SET_LOW:  ptr_n  = cmd_line;
        OP_AROT_ON:  arot_n = 1'b1;
        OP_AROT_OFF: arot_n = 1'b0;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr     <= '0;
      low_ptr <= W'(N - 1);
      arot    <= 1'b0;
    end else begin
      isr     <= (isr & ~clr) | set;
      low_ptr <= ptr_n;
      arot    <= arot_n;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N      = 8,
  parameter int BASE_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N-1:0]                  irq_in,
  input  logic [BASE_W-1:0]             cfg_base,
  input  logic                          cfg_level,
  input  logic                          cfg_auto_eoi,
  input  logic [N-1:0]                  cfg_mask,
  input  logic                          cmd_valid,
  input  logic [2:0]                    cmd_op,
  input  logic [$clog2(N)-1:0]          cmd_line,
  output logic                          int_req,
  input  logic                          int_ack,
  output logic                          vec_valid,
  output logic [BASE_W+$clog2(N)-1:0]   vec_out
);
  localparam int W     = $clog2(N);
  localparam int VEC_W = BASE_W + W;

  logic [N-1:0] irr;
  logic [N-1:0] isr;
  logic [N-1:0] clr_req;
  logic [W-1:0] low_ptr;
  logic         req_found, isr_found;
  logic [W-1:0] req_idx, isr_idx;
  logic [W-1:0] rank_req, rank_isr;
  logic         winner, grant, take;

  irq_req_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .level_mode(cfg_level),
    .clr(clr_req), .pend(irr)
  );

  irq_prio_pick #(.N(N), .W(W)) u_pick_req (
    .vec(irr & ~cfg_mask), .low(low_ptr), .found(req_found), .idx(req_idx)
  );

  irq_prio_pick #(.N(N), .W(W)) u_pick_isr (
    .vec(isr), .low(low_ptr), .found(isr_found), .idx(isr_idx)
  );

  irq_svc_state #(.N(N), .W(W)) u_svc (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_op(irq_pkg::rel_op_e'(cmd_op)), .cmd_line(cmd_line),
    .take(take), .take_idx(req_idx), .auto_rel(cfg_auto_eoi),
    .top_found(isr_found), .top_idx(isr_idx),
    .isr(isr), .low_ptr(low_ptr)
  );

  // rank 0 is the most urgent position under the current rotation
  assign rank_req = req_idx - low_ptr - W'(1);
  assign rank_isr = isr_idx - low_ptr - W'(1);
  assign winner   = req_found && (!isr_found || (rank_req < rank_isr));
  assign grant    = int_req && int_ack;
  assign take     = grant && winner;
  assign clr_req  = take ? (N'(1) << req_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_req   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      int_req   <= winner && !grant;
      vec_valid <= grant;
      if (grant) vec_out <= VEC_W'({cfg_base, (take ? req_idx : {W{1'b1}})});
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] cfg_mask,
  input logic         cfg_auto_eoi,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic [W-1:0] cmd_line,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr,
  input logic         grant,
  input logic         int_req,
  input logic         vec_valid
);
  // R5
  vec_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(grant));

  // R6
  isr_single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr & ~$past(isr)) <= 1);

  // R4
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> $past((irr & ~cfg_mask) != '0));

  // R10
  auto_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cfg_auto_eoi) |=> ((isr & ~$past(isr)) == '0));

  // R8
  line_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'b011 && !grant) |=> !isr[$past(cmd_line)]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_auto_eoi(cfg_auto_eoi),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
  .irr(irr), .isr(isr), .grant(grant), .int_req(int_req), .vec_valid(vec_valid)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic [4:0] cfg_base = 5'h0A;
  logic       cfg_level = 1'b0;
  logic       cfg_auto_eoi = 1'b0;
  logic [7:0] cfg_mask = '0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [2:0] cmd_line = '0;
  logic       int_req;
  logic       int_ack = 1'b0;
  logic       vec_valid;
  logic [7:0] vec_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_base(cfg_base),
    .cfg_level(cfg_level), .cfg_auto_eoi(cfg_auto_eoi), .cfg_mask(cfg_mask),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
    .int_req(int_req), .int_ack(int_ack), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    tick();
    tick();
  endtask

  task automatic pulse(input logic [7:0] m);
    irq_in = m;
    tick();
    irq_in = '0;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] ln);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_line  = ln;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic ack(input string tag, input int line);
    int_ack = 1'b1;
    tick();
    int_ack = 1'b0;
    chk({tag, " vec_valid"}, int'(vec_valid), 1);
    chk({tag, " vector"}, int'(vec_out), int'(cfg_base) * 8 + line);
  endtask

  task automatic serve(input string tag, input int line, input bit release_it);
    settle();
    chk({tag, " int_req"}, int'(int_req), 1);
    ack(tag, line);
    if (release_it) cmd(3'b001, 3'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 int_req after reset", int'(int_req), 0);
    chk("R1 vec_valid after reset", int'(vec_valid), 0);

    // R5 / R11 vector sweep over bases and lines
    for (int b = 0; b < 3; b++) begin
      cfg_base = (b == 0) ? 5'h01 : (b == 1) ? 5'h0E : 5'h1F;
      for (int ln = 0; ln < 8; ln++) begin
        pulse(8'(1 << ln));
        chk("R11 int_req one edge after latch", int'(int_req), 0);
        tick();
        chk("R11 int_req two edges after pulse", int'(int_req), 1);
        ack("R5", ln);
        tick();
        chk("R5 strobe one cycle", int'(vec_valid), 0);
        cmd(3'b001, 3'd0);
      end
    end
    cfg_base = 5'h0A;

    // R1 default ranking: every pair, lower number first
    for (int a = 0; a < 8; a++) begin
      for (int c = a + 1; c < 8; c++) begin
        pulse(8'((1 << a) | (1 << c)));
        serve("R1 pair first", a, 1'b1);
        serve("R1 pair second", c, 1'b1);
      end
    end

    // R6 nesting, R7 non-specific release
    pulse(8'h08);
    serve("R6 line3", 3, 1'b0);
    pulse(8'h20);
    settle();
    chk("R6 lower line blocked", int'(int_req), 0);
    pulse(8'h02);
    serve("R6 higher line nests", 1, 1'b0);
    cmd(3'b001, 3'd0);
    settle();
    chk("R7 release clears line1 only", int'(int_req), 0);
    cmd(3'b001, 3'd0);
    serve("R7 line5 after second release", 5, 1'b1);

    // R8 specific release and no-op
    pulse(8'h40);
    serve("R8 line6", 6, 1'b0);
    pulse(8'h04);
    serve("R8 line2", 2, 1'b0);
    pulse(8'h80);
    cmd(3'b011, 3'd6);
    settle();
    chk("R8 line2 still blocks", int'(int_req), 0);
    cmd(3'b010, 3'd2);
    settle();
    chk("R8 no-op keeps block", int'(int_req), 0);
    cmd(3'b011, 3'd2);
    serve("R8 line7 released", 7, 1'b1);

    // R2 edge capture: held line does not re-request
    irq_in = 8'h10;
    serve("R2 held line", 4, 1'b1);
    settle();
    chk("R2 no re-request while held", int'(int_req), 0);
    irq_in = '0;
    tick();
    pulse(8'h10);
    serve("R2 new edge", 4, 1'b1);

    // R4 mask
    cfg_mask = 8'h20;
    pulse(8'h20);
    settle();
    chk("R4 masked line quiet", int'(int_req), 0);
    cfg_mask = 8'h00;
    serve("R4 pending after unmask", 5, 1'b1);

    // R9 set-lowest sweep with all lines pending
    for (int p = 0; p < 8; p++) begin
      cmd(3'b110, 3'(p));
      pulse(8'hFF);
      for (int k = 1; k <= 8; k++) serve("R9 set lowest order", (p + k) % 8, 1'b1);
    end
    cmd(3'b110, 3'd7);

    // R9 rotate on non-specific release
    pulse(8'h04);
    serve("R9 rot-top line2", 2, 1'b0);
    cmd(3'b101, 3'd0);
    pulse(8'h0C);
    serve("R9 line3 outranks line2", 3, 1'b1);
    serve("R9 line2 last", 2, 1'b1);
    cmd(3'b110, 3'd7);

    // R9 rotate on specific release
    pulse(8'h20);
    serve("R9 rot-line line5", 5, 1'b0);
    cmd(3'b111, 3'd5);
    pulse(8'h41);
    serve("R9 line6 outranks line0", 6, 1'b1);
    serve("R9 line0 after", 0, 1'b1);
    cmd(3'b110, 3'd7);

    // R10 auto release and its rotation
    cfg_auto_eoi = 1'b1;
    pulse(8'h08);
    serve("R10 line3", 3, 1'b0);
    pulse(8'h20);
    serve("R10 lower line not blocked", 5, 1'b0);
    cmd(3'b100, 3'd0);
    pulse(8'h08);
    serve("R10 line3 rotates", 3, 1'b0);
    pulse(8'h18);
    serve("R10 line4 outranks line3", 4, 1'b0);
    serve("R10 line3 next", 3, 1'b0);
    cmd(3'b000, 3'd0);
    pulse(8'h08);
    serve("R10 rotation off", 3, 1'b0);
    pulse(8'h14);
    serve("R10 pointer held at 3", 4, 1'b0);
    serve("R10 line2 after", 2, 1'b0);
    cfg_auto_eoi = 1'b0;
    cmd(3'b110, 3'd7);

    // R3 level capture and spurious vector
    cfg_level = 1'b1;
    irq_in = 8'h40;
    settle();
    chk("R3 level request", int'(int_req), 1);
    irq_in = '0;
    tick();
    ack("R3 spurious", 7);
    irq_in = 8'h80;
    settle();
    chk("R3 line7 not in service", int'(int_req), 1);
    ack("R3 real line7", 7);
    irq_in = '0;
    cmd(3'b001, 3'd0);
    settle();
    chk("R3 pending follows input", int'(int_req), 0);
    cfg_level = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule